// File: doc/BRIEF.md
# Byte-Serial Voice Codec Port

This block is a full-duplex serial port that trades one byte per frame with an external voice codec. Software sees one data register: a write places a byte in a transmit queue and a read takes the oldest byte from a receive queue. A system-clock divider produces the serial bit clock. Every frame of `FRAME_BITS` bit clocks begins with a one-bit-clock frame-sync pulse, and one register is shared by both directions. It shifts the outgoing byte out MSB first on rising bit-clock edges and shifts the incoming byte in on falling edges.

The port has two separate enables, one for transmit and one for receive. While either enable is set, the divider, the frame sequencer and the frame interrupt run. With both enables clear, all of that logic is held idle, both queues are emptied and the status flags report empty queues. When transmit is disabled, or the transmit queue has nothing to send, the frame carries a zero byte. A maskable one-cycle interrupt marks each frame start.

Top module: `pcm_byte_port`

## Requirements
- R1: While either enable is set, `pcm_clk` is a square wave with a period of 2*`DIV_HALF` system clocks. While both enables are clear, `pcm_clk` stays low.
- R2: A frame starts every `FRAME_BITS` bit clocks. `pcm_sync` goes high on the rising `pcm_clk` edge that opens the frame and stays high for exactly one bit clock.
- R3: The frame byte is sent MSB first in the first 8 bit slots, one bit per slot. `pcm_out` changes only on rising `pcm_clk` edges and holds the MSB while `pcm_sync` is high. Slots 8 to `FRAME_BITS`-1 carry 0.
- R4: At each frame start the oldest transmit byte is moved into the shift register. A zero byte is used instead when the transmit queue is empty or `tx_en` is low, and in that case no byte is removed from the queue.
- R5: When `rx_en` is high, `pcm_in` is sampled on each falling `pcm_clk` edge of slots 0 to 7, MSB first. The assembled byte is pushed into the receive queue after the eighth sample.
- R6: When an enable is set, a `wr_en` pulse appends `wr_data` to the transmit queue. `rd_data` shows the oldest received byte, and an `rd_en` pulse removes it. Both queues keep first-in first-out order.
- R7: A write while `tx_full` is high is dropped and sets `tx_ovf`. `tx_ovf` stays set until both enables are clear.
- R8: A received byte that arrives while the receive queue already holds `DEPTH` bytes is discarded.
- R9: While `tx_en` is low, `pcm_out` is 0.
- R10: While both enables are clear, `rx_empty` reads 1 and `tx_full` reads 0, both queues are emptied, writes are ignored, and `pcm_sync` and `irq` stay low.
- R11: `irq` is a one-system-cycle pulse in the first cycle of each `pcm_sync` pulse, provided `irq_mask` was low at that frame start. It never fires otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| irq_mask | input | 1 | Suppresses the frame interrupt when high |
| wr_en | input | 1 | Data register write strobe (push to transmit queue) |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Data register read strobe (pop from receive queue) |
| rd_data | output | 8 | Oldest received byte |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_ovf | output | 1 | Sticky transmit overflow |
| pcm_clk | output | 1 | Serial bit clock |
| pcm_sync | output | 1 | Frame sync, one bit clock wide |
| pcm_out | output | 1 | Serial data to codec |
| pcm_in | input | 1 | Serial data from codec |
| irq | output | 1 | Frame-start interrupt pulse |

## Verification
Two situations are hard to reach from the ports: a receive queue that overflows, and a disable that arrives while both queues hold data. The bench feeds `pcm_out` back to `pcm_in` through an optional inverter, so the receive path gets known bytes. With transmit disabled and inversion on, every frame delivers 0xFF. Leaving reads off for more frames than the queue depth then forces the discard case. A separate pass fills the transmit queue, lets 0xFF bytes collect on the receive side, and clears both enables mid-frame. It then writes while disabled and checks that the frames after re-enable carry only zeros.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  localparam int PCM_BITS = 8;

  typedef logic [PCM_BITS-1:0] pcm_byte_t;

  // bit-clock edge strobes, valid one system cycle before the pin changes
  typedef struct packed {
    logic rise;
    logic fall;
  } pcm_edge_t;

endpackage

// File: rtl/pcm_fifo.sv
module pcm_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_n;
  logic [AW-1:0] rd_ptr_q, rd_ptr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_FULL);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign dout    = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    cnt_n    = cnt_q;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      cnt_n    = '0;
    end else begin
      if (do_push) wr_ptr_n = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_n = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= din;
  end

endmodule

// File: rtl/pcm_bitclk.sv
module pcm_bitclk
  import pcm_port_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  output logic      pcm_clk,
  output pcm_edge_t edges
);

  localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             clk_q, clk_n;
  logic             at_last;

  assign at_last    = (cnt_q == CNT_LAST);
  assign edges.rise = run & at_last & ~clk_q;
  assign edges.fall = run & at_last & clk_q;
  assign pcm_clk    = clk_q;

  always_comb begin
    cnt_n = cnt_q;
    clk_n = clk_q;
    if (!run) begin
      cnt_n = '0;
      clk_n = 1'b0;
    end else if (at_last) begin
      cnt_n = '0;
      clk_n = ~clk_q;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      clk_q <= clk_n;
    end
  end

endmodule

// File: rtl/pcm_frame_engine.sv
module pcm_frame_engine
  import pcm_port_pkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      tx_en,
  input  logic      rx_en,
  input  logic      irq_mask,
  input  pcm_edge_t edges,
  input  logic      tx_empty,
  input  pcm_byte_t tx_head,
  input  logic      pcm_in,
  output logic      tx_pop,
  output logic      rx_push,
  output pcm_byte_t rx_byte,
  output logic      out_bit,
  output logic      sync,
  output logic      irq
);

  localparam int SW = $clog2(FRAME_BITS);
  localparam logic [SW-1:0] SLOT_LAST = SW'(FRAME_BITS - 1);
  localparam logic [SW-1:0] DATA_END  = SW'(PCM_BITS);
  localparam logic [SW-1:0] LAST_BIT  = SW'(PCM_BITS - 1);

  logic [SW-1:0] slot_q, slot_n;
  pcm_byte_t     sreg_q, sreg_n;
  logic          out_q, out_n;
  logic          sync_q, sync_n;
  logic          irq_q, irq_n;

  assign out_bit = out_q;
  assign sync    = sync_q;
  assign irq     = irq_q;
  assign rx_byte = {sreg_q[PCM_BITS-2:0], pcm_in};

  always_comb begin
    slot_n  = slot_q;
    sreg_n  = sreg_q;
    out_n   = out_q;
    sync_n  = sync_q;
    irq_n   = 1'b0;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    if (!run) begin
      slot_n = SLOT_LAST;
      sreg_n = '0;
      out_n  = 1'b0;
      sync_n = 1'b0;
    end else if (edges.rise) begin
      sync_n = 1'b0;
      if (slot_q == SLOT_LAST) begin
        slot_n = '0;
        tx_pop = tx_en & ~tx_empty;
        sreg_n = tx_pop ? tx_head : '0;
        out_n  = sreg_n[PCM_BITS-1];
        sync_n = 1'b1;
        irq_n  = ~irq_mask;
      end else begin
        slot_n = slot_q + 1'b1;
        out_n  = (slot_n < DATA_END) ? sreg_q[PCM_BITS-1] : 1'b0;
      end
    end else if (edges.fall && (slot_q < DATA_END)) begin
      sreg_n  = {sreg_q[PCM_BITS-2:0], pcm_in};
      rx_push = rx_en & (slot_q == LAST_BIT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SLOT_LAST;
      sreg_q <= '0;
      out_q  <= 1'b0;
      sync_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      slot_q <= slot_n;
      sreg_q <= sreg_n;
      out_q  <= out_n;
      sync_q <= sync_n;
      irq_q  <= irq_n;
    end
  end

endmodule

// File: rtl/pcm_byte_port.sv
module pcm_byte_port
  import pcm_port_pkg::*;
#(
  parameter int DIV_HALF   = 4,
  parameter int FRAME_BITS = 16,
  parameter int DEPTH      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic       irq_mask,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       tx_full,
  output logic       rx_empty,
  output logic       tx_ovf,
  output logic       pcm_clk,
  output logic       pcm_sync,
  output logic       pcm_out,
  input  logic       pcm_in,
  output logic       irq
);

  logic      run;
  pcm_edge_t edges;
  logic      txq_empty, txq_full, rxq_empty, rxq_full;
  pcm_byte_t txq_head;
  logic      tx_pop, rx_push;
  pcm_byte_t rx_byte;
  logic      out_bit;
  logic      ovf_q, ovf_n;

  assign run = tx_en | rx_en;

  pcm_bitclk #(.DIV_HALF(DIV_HALF)) i_bitclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .pcm_clk (pcm_clk),
    .edges   (edges)
  );

  pcm_fifo #(.DEPTH(DEPTH), .W(PCM_BITS)) i_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (~run),
    .push  (wr_en & run),
    .din   (wr_data),
    .pop   (tx_pop),
    .dout  (txq_head),
    .empty (txq_empty),
    .full  (txq_full)
  );

  pcm_fifo #(.DEPTH(DEPTH), .W(PCM_BITS)) i_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (~run),
    .push  (rx_push),
    .din   (rx_byte),
    .pop   (rd_en & run),
    .dout  (rd_data),
    .empty (rxq_empty),
    .full  (rxq_full)
  );

  pcm_frame_engine #(.FRAME_BITS(FRAME_BITS)) i_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .irq_mask (irq_mask),
    .edges    (edges),
    .tx_empty (txq_empty),
    .tx_head  (txq_head),
    .pcm_in   (pcm_in),
    .tx_pop   (tx_pop),
    .rx_push  (rx_push),
    .rx_byte  (rx_byte),
    .out_bit  (out_bit),
    .sync     (pcm_sync),
    .irq      (irq)
  );

  // a full receive queue ignores the push inside the FIFO
  logic unused_rxq_full;
  assign unused_rxq_full = rxq_full;

  assign rx_empty = ~run | rxq_empty;
  assign tx_full  = run & txq_full;
  assign pcm_out  = tx_en & out_bit;
  assign tx_ovf   = ovf_q;

  always_comb begin
    if (!run) ovf_n = 1'b0;
    else      ovf_n = ovf_q | (wr_en & txq_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_n;
  end

endmodule

// File: rtl/pcm_byte_port_checker.sv
module pcm_byte_port_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic rx_en,
  input logic irq_mask,
  input logic wr_en,
  input logic tx_full,
  input logic rx_empty,
  input logic tx_ovf,
  input logic pcm_clk,
  input logic pcm_sync,
  input logic pcm_out,
  input logic irq
);

  logic act;
  assign act = tx_en | rx_en;

  a_r2_sync_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_sync) |-> $rose(pcm_clk));

  a_r2_sync_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pcm_sync) && act && $past(act)) |-> $rose(pcm_clk));

  a_r3_out_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pcm_out) && tx_en && $past(tx_en)) |-> $rose(pcm_clk));

  a_r9_out_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !pcm_out);

  a_r10_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> (rx_empty && !tx_full));

  a_r10_logic_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !$past(act)) |-> (!pcm_clk && !pcm_sync && !irq));

  a_r7_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_full) |=> tx_ovf);

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf && act) |=> tx_ovf);

  a_r11_irq_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($rose(pcm_sync) && !$past(irq_mask)));

  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

endmodule

bind pcm_byte_port pcm_byte_port_checker i_pcm_byte_port_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_en    (tx_en),
  .rx_en    (rx_en),
  .irq_mask (irq_mask),
  .wr_en    (wr_en),
  .tx_full  (tx_full),
  .rx_empty (rx_empty),
  .tx_ovf   (tx_ovf),
  .pcm_clk  (pcm_clk),
  .pcm_sync (pcm_sync),
  .pcm_out  (pcm_out),
  .irq      (irq)
);

// File: tb/test_pcm_byte_port.sv
`timescale 1ns/1ps
module test_pcm_byte_port;

  localparam int DIVH = 2;
  localparam int FB   = 10;
  localparam int DEP  = 4;
  localparam int BITP = 2 * DIVH;
  localparam int FRP  = BITP * FB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, rx_en = 1'b0, irq_mask = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tx_full, rx_empty, tx_ovf, pcm_clk, pcm_sync, pcm_out, pcm_in, irq;
  logic       inv = 1'b0;

  assign pcm_in = pcm_out ^ inv;

  always #2 clk = ~clk;

  pcm_byte_port #(.DIV_HALF(DIVH), .FRAME_BITS(FB), .DEPTH(DEP)) i_pcm_byte_port (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .irq_mask(irq_mask),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .tx_full(tx_full), .rx_empty(rx_empty), .tx_ovf(tx_ovf), .pcm_clk(pcm_clk),
    .pcm_sync(pcm_sync), .pcm_out(pcm_out), .pcm_in(pcm_in), .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // serial monitor, sampled on the falling system clock edge
  int         cyc = 0;
  logic       prev_clk = 1'b0, prev_sync = 1'b0;
  int         last_rise = -1, last_sync = -1, sync_len = 0;
  int         scnt = 0, rcnt = 0, irq_cnt = 0, bitn = 8, cur_f = 0;
  logic [7:0] cap = 8'h00;
  logic [7:0] txcap [256];

  initial for (int i = 0; i < 256; i++) txcap[i] = 8'hEE;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (irq) irq_cnt++;
      if (pcm_clk && !prev_clk) begin
        rcnt++;
        if (last_rise >= 0) chk(cyc - last_rise == BITP, "R1 bit clock period", cyc - last_rise, BITP);
        last_rise = cyc;
        if (!tx_en) chk(pcm_out == 1'b0, "R9 output idle while tx disabled", pcm_out, 0);
        if (pcm_sync) begin
          if (last_sync >= 0) chk(cyc - last_sync == FRP, "R2 frame period", cyc - last_sync, FRP);
          last_sync = cyc;
          cur_f = scnt;
          scnt++;
          cap = {7'b0, pcm_out};
          bitn = 1;
        end else if (bitn < 8) begin
          cap = {cap[6:0], pcm_out};
          bitn++;
          if (bitn == 8) txcap[cur_f[7:0]] = cap;
        end else begin
          chk(pcm_out == 1'b0, "R3 unused slot carries zero", pcm_out, 0);
        end
      end
      if (pcm_sync) sync_len++;
      else begin
        if (prev_sync && (tx_en | rx_en)) chk(sync_len == BITP, "R2 sync width", sync_len, BITP);
        sync_len = 0;
      end
      if (!(tx_en | rx_en)) begin
        last_rise = -1;
        last_sync = -1;
        bitn = 8;
      end
    end
    prev_clk  = pcm_clk;
    prev_sync = pcm_sync;
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_sync(input int n);
    int target;
    target = scnt + n;
    while (scnt < target) @(posedge clk);
    #1;
  endtask

  task automatic write_byte(input logic [7:0] b);
    wr_en = 1'b1;
    wr_data = b;
    step();
    wr_en = 1'b0;
  endtask

  task automatic read_expect(input logic [7:0] exp, input string tag);
    chk(rx_empty == 1'b0, {tag, " data present"}, rx_empty, 0);
    chk(rd_data == exp, tag, rd_data, exp);
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int k);
    return (k < 8) ? (8'h01 << k) : ~(8'h01 << (k - 8));
  endfunction

  int f0, i0, s0, r0;

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // reset state
    chk(rx_empty == 1'b1, "R10 reset rx_empty", rx_empty, 1);
    chk(tx_full == 1'b0, "R10 reset tx_full", tx_full, 0);
    chk(tx_ovf == 1'b0, "R7 reset tx_ovf", tx_ovf, 0);
    chk({pcm_clk, pcm_sync, pcm_out, irq} == 4'b0, "R10 reset serial pins", {pcm_clk, pcm_sync, pcm_out, irq}, 0);
    r0 = rcnt;
    repeat (20) step();
    chk(rcnt == r0, "R1 no bit clock while disabled", rcnt - r0, 0);

    // phase A: loopback sweep of walking ones and zeros
    tx_en = 1'b1; rx_en = 1'b1; inv = 1'b0;
    wait_sync(1);
    f0 = scnt - 1;
    i0 = irq_cnt;
    s0 = scnt;
    for (int k = 0; k < 16; k++) begin
      write_byte(pat(k));
      wait_sync(1);
      read_expect((k == 0) ? 8'h00 : pat(k - 1), "R5 R6 loopback receive");
    end
    wait_sync(2);
    chk(irq_cnt - i0 == scnt - s0, "R11 one irq per frame", irq_cnt - i0, scnt - s0);
    chk(txcap[f0[7:0]] == 8'h00, "R4 empty queue sends zero", txcap[f0[7:0]], 0);
    for (int k = 1; k <= 16; k++)
      chk(txcap[8'(f0 + k)] == pat(k - 1), "R3 serial byte MSB first", txcap[8'(f0 + k)], pat(k - 1));
    tx_en = 1'b0; rx_en = 1'b0;
    step(); step();

    // phase B: transmit overflow, rx disabled
    tx_en = 1'b1;
    wait_sync(1);
    f0 = scnt - 1;
    write_byte(8'h11); write_byte(8'h22); write_byte(8'h33);
    chk(tx_full == 1'b0, "R7 not full at depth-1", tx_full, 0);
    write_byte(8'h44);
    chk(tx_full == 1'b1, "R7 full at depth", tx_full, 1);
    chk(tx_ovf == 1'b0, "R7 no overflow yet", tx_ovf, 0);
    write_byte(8'h55);
    chk(tx_ovf == 1'b1, "R7 overflow flagged", tx_ovf, 1);
    wait_sync(6);
    chk(txcap[8'(f0 + 1)] == 8'h11, "R6 order first", txcap[8'(f0 + 1)], 8'h11);
    chk(txcap[8'(f0 + 2)] == 8'h22, "R6 order second", txcap[8'(f0 + 2)], 8'h22);
    chk(txcap[8'(f0 + 3)] == 8'h33, "R6 order third", txcap[8'(f0 + 3)], 8'h33);
    chk(txcap[8'(f0 + 4)] == 8'h44, "R6 order fourth", txcap[8'(f0 + 4)], 8'h44);
    chk(txcap[8'(f0 + 5)] == 8'h00, "R7 dropped byte not sent", txcap[8'(f0 + 5)], 0);
    chk(tx_ovf == 1'b1, "R7 overflow sticky", tx_ovf, 1);

    // phase C: disable with both queues holding data
    rx_en = 1'b1; inv = 1'b1;
    wait_sync(1);
    write_byte(8'hC1); write_byte(8'hC2); write_byte(8'hC3); write_byte(8'hC4);
    wait_sync(2);
    write_byte(8'hC5); write_byte(8'hC6);
    chk(tx_full == 1'b1, "R10 tx queue full before disable", tx_full, 1);
    chk(rx_empty == 1'b0, "R10 rx queue holds data before disable", rx_empty, 0);
    repeat (5) step();
    tx_en = 1'b0; rx_en = 1'b0;
    #0.5;
    chk(tx_full == 1'b0, "R10 tx_full reads clear when disabled", tx_full, 0);
    chk(rx_empty == 1'b1, "R10 rx_empty reads set when disabled", rx_empty, 1);
    step(); step();
    chk(tx_ovf == 1'b0, "R7 overflow cleared by disable", tx_ovf, 0);
    r0 = rcnt; i0 = irq_cnt;
    write_byte(8'hAB); write_byte(8'hCD);
    repeat (30) step();
    chk(rcnt == r0, "R1 bit clock stopped", rcnt - r0, 0);
    chk(irq_cnt == i0, "R10 no irq while disabled", irq_cnt - i0, 0);
    chk(pcm_sync == 1'b0, "R10 sync idle", pcm_sync, 0);
    tx_en = 1'b1; rx_en = 1'b1; inv = 1'b0;
    step();
    chk(rx_empty == 1'b1, "R10 rx queue emptied", rx_empty, 1);
    chk(tx_full == 1'b0, "R10 tx queue emptied", tx_full, 0);
    wait_sync(1);
    f0 = scnt - 1;
    wait_sync(2);
    chk(txcap[f0[7:0]] == 8'h00, "R10 flushed queue sends zero", txcap[f0[7:0]], 0);
    chk(txcap[8'(f0 + 1)] == 8'h00, "R10 disabled writes ignored", txcap[8'(f0 + 1)], 0);
    tx_en = 1'b0; rx_en = 1'b0;
    step(); step();

    // phase D: receive only with inverted loopback, overfill rx queue
    rx_en = 1'b1; inv = 1'b1;
    write_byte(8'h77);
    wait_sync(DEP + 3);
    for (int k = 0; k < DEP; k++) read_expect(8'hFF, "R8 R9 received FF while tx off");
    chk(rx_empty == 1'b1, "R8 extra bytes discarded", rx_empty, 1);
    tx_en = 1'b1; inv = 1'b0;
    wait_sync(1);
    f0 = scnt - 1;
    wait_sync(1);
    chk(txcap[f0[7:0]] == 8'h77, "R4 byte kept while tx off", txcap[f0[7:0]], 8'h77);

    // phase E: interrupt mask
    irq_mask = 1'b1;
    i0 = irq_cnt;
    wait_sync(3);
    chk(irq_cnt == i0, "R11 masked irq", irq_cnt - i0, 0);
    irq_mask = 1'b0;
    i0 = irq_cnt;
    wait_sync(3);
    chk(irq_cnt - i0 == 3, "R11 unmasked irq", irq_cnt - i0, 3);

    tx_en = 1'b0; rx_en = 1'b0;
    step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule